// File: doc/BRIEF.md
# Pseudo-carry prefix adder

This block adds two unsigned binary words and a carry-in. It produces a sum word and a carry-out. Inside, it never forms true carries in its lookahead tree. For each bit it builds a factored pseudo-carry H, which leaves out the leading OR-propagate factor. The true carry out of any position is then the AND of that position's propagate with its pseudo-carry. Each product in the tree loses one term, so the critical path gets shallower.

The tree combines (pseudo-carry, shifted propagate) pairs. A group's propagate is taken one bit below the group, so an upper group absorbs the lower group's pseudo-carry through the propagate of the bit just under its own bottom. The carry-in acts as a generate term below bit 0. A parameter picks one of two tree shapes:

- a dense tree that computes every position;
- a sparse tree that computes only odd positions and fills in the even ones in one last level.

An output register, on by default, holds the result for timing closure. The adder core stays combinational.

Top module: `pcarry_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, with all values unsigned.
- R2: `cout` equals bit WIDTH (the carry-out bit) of `a + b + cin`.
- R3: Bit propagate is the inclusive OR of the operand bits. For every bit n, that propagate ANDed with the pseudo-carry of bit n equals the true carry out of bit n.
- R4: The pseudo-carry of bit 1 is `a[1]&b[1] | a[0]&b[0] | (a[0]|b[0])&cin`. It needs no propagate of bit 1. In the results, operand pairs that differ only in bit 1 of one operand give sums that differ exactly as the arithmetic predicts.
- R5: The carry-in enters below bit 0. Zero operands with `cin`=1 give `sum`=1 and `cout`=0. All-ones operands with `cin`=1 give an all-ones `sum` and `cout`=1.
- R6: When REG_OUT=1, `sum` and `cout` are registered. An active-low asynchronous `rst_n` clears both to 0. A new input appears at the outputs after the next rising clock edge, and not before it.
- R7: Both tree shapes give identical results for every input: TREE=0 (every position) and TREE=1 (odd positions first, then an even fill-in level).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry-out |

## Verification
An 8-bit configuration of both tree shapes is swept over every operand pair, with the carry-in toggling through the sweep. This exposes any wrong merge distance, any mis-shifted propagate and any missing fill-in node, since every carry chain length from every start bit is hit. The 32-bit configurations get three kinds of vectors, each separating a different fault:

- all-zero, all-ones and alternating patterns, which pit full-length propagation against isolated generates and show whether the carry-in is folded in at the bottom;
- pairs that differ only around bits 0 and 1, which isolate the base pseudo-carry;
- random words, which cover mixed chains.

The reset value and the one-edge latency are observed directly at the outputs.

// File: rtl/pcarry_pkg.sv
package pcarry_pkg;

  localparam int PC_TREE_DENSE  = 0;
  localparam int PC_TREE_SPARSE = 1;

  // One prefix element: pseudo-carry and the propagate taken one bit below.
  typedef struct packed {
    logic h;
    logic q;
  } pc_node_t;

  // Upper group absorbs the lower one through its shifted propagate.
  function automatic pc_node_t pc_merge(pc_node_t hi, pc_node_t lo);
    pc_node_t r;
    r.h = hi.h | (hi.q & lo.h);
    r.q = hi.q & lo.q;
    return r;
  endfunction

endpackage

// File: rtl/pcarry_bit_terms.sv
module pcarry_bit_terms
  import pcarry_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int NODES = WIDTH + 1
) (
  input  logic [WIDTH-1:0]     a,
  input  logic [WIDTH-1:0]     b,
  input  logic                 cin,
  output logic [WIDTH-1:0]     p,
  output logic [WIDTH-1:0]     t,
  output pc_node_t [NODES-1:0] leaf
);

  logic [WIDTH-1:0] g;

  always_comb begin
    g = a & b;
    p = a | b;
    t = a ^ b;
  end

  // Element 0 carries the carry-in as a generate below bit 0.
  assign leaf[0].h = cin;
  assign leaf[0].q = 1'b0;

  genvar e;
  generate
    for (e = 1; e < NODES; e++) begin : g_leaf
      assign leaf[e].h = g[e-1];
      if (e == 1) begin : g_first
        assign leaf[e].q = 1'b1;
      end else begin : g_rest
        assign leaf[e].q = p[e-2];
      end
    end
  endgenerate

endmodule

// File: rtl/pcarry_prefix_tree.sv
module pcarry_prefix_tree
  import pcarry_pkg::*;
#(
  parameter int NODES = 33,
  parameter int TREE  = PC_TREE_DENSE,
  localparam int LVL    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int STAGES = (TREE == PC_TREE_SPARSE) ? LVL + 1 : LVL
) (
  input  pc_node_t [NODES-1:0] leaf,
  output logic     [NODES-1:0] hout
);

  pc_node_t [NODES-1:0] lvl [0:STAGES];

  assign lvl[0] = leaf;

  genvar st, i;
  generate
    for (st = 0; st < STAGES; st++) begin : g_stage
      for (i = 0; i < NODES; i++) begin : g_node
        localparam bit FILL = (TREE == PC_TREE_SPARSE) && (st == LVL);
        localparam int DIST = FILL ? 1 : (1 << st);
        localparam bit ODD_OK = (TREE != PC_TREE_SPARSE) || ((i % 2) == 1);
        localparam bit ACTIVE = FILL ? (((i % 2) == 0) && (i >= 2))
                                     : (ODD_OK && (i >= DIST));
        if (ACTIVE) begin : g_merge
          assign lvl[st+1][i] = pc_merge(lvl[st][i], lvl[st][i-DIST]);
        end else begin : g_pass
          assign lvl[st+1][i] = lvl[st][i];
        end
      end
    end
    for (i = 0; i < NODES; i++) begin : g_out
      assign hout[i] = lvl[STAGES][i].h;
    end
  endgenerate

endmodule

// File: rtl/pcarry_sum_stage.sv
module pcarry_sum_stage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] t,
  input  logic [WIDTH-1:0] p,
  input  logic [WIDTH-1:0] h,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH-1:0] carry;

  always_comb begin
    carry = p & h;
    sum[0] = t[0] ^ cin;
    for (int n = 1; n < WIDTH; n++) begin
      sum[n] = t[n] ^ carry[n-1];
    end
    cout = carry[WIDTH-1];
  end

endmodule

// File: rtl/pcarry_adder.sv
module pcarry_adder
  import pcarry_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int TREE    = PC_TREE_DENSE,
  parameter bit REG_OUT = 1'b1,
  localparam int NODES = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  pc_node_t [NODES-1:0] leaf;
  logic [WIDTH-1:0]     p_bits;
  logic [WIDTH-1:0]     t_bits;
  logic [NODES-1:0]     h_all;
  logic [WIDTH-1:0]     h_vec;
  logic [WIDTH-1:0]     sum_d;
  logic                 cout_d;

  pcarry_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .p    (p_bits),
    .t    (t_bits),
    .leaf (leaf)
  );

  pcarry_prefix_tree #(.NODES(NODES), .TREE(TREE)) u_tree (
    .leaf (leaf),
    .hout (h_all)
  );

  // Element n+1 holds the pseudo-carry of bit n.
  assign h_vec = h_all[NODES-1:1];

  pcarry_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .t    (t_bits),
    .p    (p_bits),
    .h    (h_vec),
    .cin  (cin),
    .sum  (sum_d),
    .cout (cout_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] sum_q;
      logic             cout_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum_q  <= '0;
          cout_q <= 1'b0;
        end else begin
          sum_q  <= sum_d;
          cout_q <= cout_d;
        end
      end
      assign sum  = sum_q;
      assign cout = cout_q;
    end else begin : g_comb
      assign sum  = sum_d;
      assign cout = cout_d;
    end
  endgenerate

endmodule

// File: rtl/pcarry_adder_chk.sv
module pcarry_adder_chk #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH-1:0] p_bits,
  input logic [WIDTH-1:0] h_vec
);

  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] ref_cin_vec;
  logic           armed;

  always_comb begin
    ref_full    = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    ref_cin_vec = {1'b0, a} ^ {1'b0, b} ^ ref_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_LING_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (p_bits & h_vec) == ref_cin_vec[WIDTH:1]);  // R3

  if (WIDTH >= 2) begin : g_base
    AST_BASE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      h_vec[1] == ((a[1] & b[1]) | (a[0] & b[0]) | ((a[0] | b[0]) & cin)));  // R4
  end

  if (REG_OUT) begin : g_regd
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> sum == $past(ref_full[WIDTH-1:0]));  // R1
    AST_COUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cout == $past(ref_full[WIDTH]));  // R2
    AST_CIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 && b == '0 && cin) |=> (sum == WIDTH'(1) && !cout));  // R5
  end

endmodule

bind pcarry_adder pcarry_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a      (a),
  .b      (b),
  .cin    (cin),
  .sum    (sum),
  .cout   (cout),
  .p_bits (p_bits),
  .h_vec  (h_vec)
);

// File: tb/test_pcarry_adder.sv
module test_pcarry_adder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        cin = 1'b0;
  logic [31:0] s32d, s32s;
  logic [7:0]  s8d, s8s;
  logic        c32d, c32s, c8d, c8s;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pcarry_adder #(.WIDTH(32), .TREE(0)) i_pcarry_adder (
    .clk(clk), .rst_n(rst_n), .a(a32), .b(b32), .cin(cin), .sum(s32d), .cout(c32d));
  pcarry_adder #(.WIDTH(32), .TREE(1)) i_pcarry_adder_sp (
    .clk(clk), .rst_n(rst_n), .a(a32), .b(b32), .cin(cin), .sum(s32s), .cout(c32s));
  pcarry_adder #(.WIDTH(8), .TREE(0)) i_pcarry_adder_d8 (
    .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .cin(cin), .sum(s8d), .cout(c8d));
  pcarry_adder #(.WIDTH(8), .TREE(1)) i_pcarry_adder_s8 (
    .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .cin(cin), .sum(s8s), .cout(c8s));

  task automatic check(input logic [32:0] act, input logic [32:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Drive at a falling edge, observe at the next falling edge.
  task automatic apply32(input logic [31:0] x, input logic [31:0] y, input logic c, input string tag);
    logic [32:0] exp;
    a32 = x; b32 = y; cin = c;
    exp = {1'b0, x} + {1'b0, y} + {32'd0, c};
    @(posedge clk);
    @(negedge clk);
    check({1'b0, s32d}, {1'b0, exp[31:0]}, {"R1 ", tag});
    check({32'd0, c32d}, {32'd0, exp[32]}, {"R2 ", tag});
    check({c32s, s32s}, exp, {"R7 ", tag});
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [32:0] e;
    // R6: reset state with live inputs
    a32 = 32'h1234_5678; b32 = 32'h0F0F_0F0F; cin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({c32d, s32d}, 33'd0, "R6 reset clear");
    check({c32s, s32s}, 33'd0, "R6 reset clear sparse");
    rst_n = 1'b1;

    apply32(32'd0, 32'd0, 1'b0, "all zero");
    // R6: latency - new inputs not visible before the edge
    a32 = 32'd100; b32 = 32'd23; cin = 1'b0;
    #1;
    check({c32d, s32d}, 33'd0, "R6 before edge");
    @(posedge clk);
    @(negedge clk);
    check({c32d, s32d}, 33'd123, "R6 after edge");

    apply32(32'd0, 32'd0, 1'b1, "R5 cin only");
    check({c32d, s32d}, 33'd1, "R5 cin only");
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 all ones");
    check({c32d, s32d}, {1'b1, 32'hFFFF_FFFF}, "R5 all ones");
    apply32(32'hFFFF_FFFF, 32'd0, 1'b1, "full ripple");
    check({c32d, s32d}, {1'b1, 32'd0}, "R3 full ripple");
    apply32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "alt");
    apply32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "alt cin");
    apply32(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "alt same");
    apply32(32'h5555_5555, 32'h5555_5555, 1'b1, "alt same cin");
    // R4: base pair, bit 1 propagate decides
    apply32(32'd1, 32'd1, 1'b0, "R4 p1 off");
    check({c32d, s32d}, 33'd2, "R4 p1 off");
    apply32(32'd3, 32'd1, 1'b0, "R4 p1 on");
    check({c32d, s32d}, 33'd4, "R4 p1 on");
    apply32(32'd2, 32'd1, 1'b1, "R4 cin through p0");
    check({c32d, s32d}, 33'd4, "R4 cin through p0");

    for (int k = 0; k < 1500; k++) begin
      apply32($urandom, $urandom, 1'($urandom), "random");
    end

    // R7 / R1 / R2 exhaustive 8-bit sweep of both tree shapes
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        a8 = 8'(x); b8 = 8'(y); cin = 1'(x ^ (y >> 1));
        e = 33'(x) + 33'(y) + 33'(cin);
        @(posedge clk);
        @(negedge clk);
        check({24'd0, c8d, s8d}, {24'd0, e[8:0]}, "R1 R2 sweep dense");
        check({24'd0, c8s, s8s}, {24'd0, e[8:0]}, "R7 sweep sparse");
      end
    end

    summary();
  end

endmodule